// File: doc/BRIEF.md
# I2C Serial Clock Generator

This block produces the serial clock of an I2C controller from its module clock. The clock is divided first by a programmable prescaler. It is then split into a low phase and a high phase, and each phase has its own count. Each phase lasts its programmed count plus a fixed offset, in prescaled ticks. The offset depends on the prescaler value. A build parameter selects a variant in which the offset is constant.

The generator drives the line only by pulling it low. The bit-level engine receives a one-cycle strobe at each phase change and uses it to place SDA transitions. The engine also supplies a clock enable that freezes the generator while the bus is idle. During the high phase, the generator watches the actual line level, so a device that holds SCL low stretches that phase.

The prescaler and phase counts are loaded through a small write port. That port only accepts writes while the run control is low. Raising the run control starts clock generation, and the low phase comes first.

Top module: `sclClockGen`

## Requirements
- R1: While `runEn` is low (and after reset), `sclDriveLow` and `phaseStrobe` are 0 and all counters are held at zero.
- R2: In the first cycle in which `runEn` and `genEn` are both high after an idle period, the next clock edge starts a low phase: `sclDriveLow` goes to 1 together with `phaseStrobe`.
- R3: With prescale value P and low count L, the low phase lasts (P+1)×(L+d) clock cycles.
- R4: With high count H and no stretching, the high phase lasts (P+1)×(H+d) clock cycles, and phases alternate low, high, low and so on.
- R5: When `FIXED_OFFSET` is 0, d is 7 for P=0, 6 for P=1 and 5 for P≥2.
- R6: When `FIXED_OFFSET` is 1, d is 6 for every P.
- R7: A high count of 0 is legal and gives a high phase of (P+1)×d cycles.
- R8: A write through `cfgWe` is applied only while `runEn` is low. A write made while running has no effect on the current run or on later runs. `cfgSel` encodes the target: 0 is the prescaler (low `PSC_W` bits of `cfgData`), 1 is the low count, 2 is the high count, and 3 is ignored. All three values reset to 0.
- R9: Each cycle in which `genEn` is low while running freezes the generator: `sclDriveLow` holds, no strobe appears, and the current phase grows by one cycle.
- R10: During a high phase, each cycle in which `sclIn` is low holds the countdown, so the high phase grows by the number of such cycles.
- R11: While running, `phaseStrobe` pulses for exactly one cycle in the same cycle that `sclDriveLow` changes, and at no other time.
- R12: Dropping `runEn` in the middle of a phase releases SCL at the next edge with no strobe. A later start begins with a full low phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rstN | input | 1 | Active-low synchronous reset |
| runEn | input | 1 | Run control: 0 holds the generator idle and opens the write port |
| genEn | input | 1 | Clock enable from the bit engine; 0 freezes generation |
| cfgWe | input | 1 | Write strobe for the divider settings |
| cfgSel | input | 2 | Write target: 0 prescaler, 1 low count, 2 high count |
| cfgData | input | CNT_W | Write data |
| sclIn | input | 1 | Sampled SCL line level |
| sclDriveLow | output | 1 | 1 pulls SCL low; 0 releases it |
| phaseStrobe | output | 1 | One-cycle pulse at every phase start |

## Verification
The main division is tried with three settings: prescale 0, prescale 1, and prescale 3 with a high count of 0. Together these tell apart the three offset values and the zero-count edge case. The constant-offset variant runs alongside with the same settings. Any difference in phase length between the two builds shows that the offset selection, and not the count arithmetic, is what depends on the prescaler. Separate runs freeze the clock enable during a low phase, hold the line low during a high phase, write the settings mid-run, and stop mid-phase. Each of these shifts exactly one measured phase by a known number of cycles, or leaves the phases unchanged.

// File: rtl/sclGenPkg.sv
package sclGenPkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_HIGH = 2'd2
  } phaseState_t;

  // strobes from phase control to the divider datapath
  typedef struct packed {
    logic clear;
    logic loadLow;
    logic loadHigh;
    logic count;
  } dpCtl_t;

  localparam logic [1:0] SEL_PRESCALE = 2'd0;
  localparam logic [1:0] SEL_LOW      = 2'd1;
  localparam logic [1:0] SEL_HIGH     = 2'd2;

  localparam int OFF_W = 3;

endpackage

// File: rtl/sclDivDatapath.sv
module sclDivDatapath
  import sclGenPkg::*;
#(
  parameter int PSC_W        = 8,
  parameter int CNT_W        = 16,
  parameter bit FIXED_OFFSET = 1'b0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             runEn,
  input  logic             cfgWe,
  input  logic [1:0]       cfgSel,
  input  logic [CNT_W-1:0] cfgData,
  input  dpCtl_t           ctl,
  output logic             atLast
);

  localparam int LEN_W = CNT_W + 1;

  logic [PSC_W-1:0] pscReg;
  logic [CNT_W-1:0] lowReg;
  logic [CNT_W-1:0] highReg;
  logic [PSC_W-1:0] preCnt;
  logic [LEN_W-1:0] phCnt;
  logic [OFF_W-1:0] offset;
  logic [LEN_W-1:0] lowLen;
  logic [LEN_W-1:0] highLen;
  logic             preWrap;

  // settings accepted only while the controller is held idle
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pscReg  <= '0;
      lowReg  <= '0;
      highReg <= '0;
    end else if (cfgWe && !runEn) begin
      case (cfgSel)
        SEL_PRESCALE: pscReg  <= cfgData[PSC_W-1:0];
        SEL_LOW:      lowReg  <= cfgData;
        SEL_HIGH:     highReg <= cfgData;
        default: ;
      endcase
    end
  end

  generate
    if (FIXED_OFFSET) begin : gFixedOff
      assign offset = OFF_W'(6);
    end else begin : gScaledOff
      always_comb begin
        if (pscReg == '0)                 offset = OFF_W'(7);
        else if (pscReg == PSC_W'(1))     offset = OFF_W'(6);
        else                              offset = OFF_W'(5);
      end
    end
  endgenerate

  assign lowLen  = {1'b0, lowReg}  + LEN_W'(offset);
  assign highLen = {1'b0, highReg} + LEN_W'(offset);
  assign preWrap = (preCnt == pscReg);
  assign atLast  = preWrap && (phCnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN || ctl.clear) begin
      preCnt <= '0;
      phCnt  <= '0;
    end else if (ctl.loadLow) begin
      preCnt <= '0;
      phCnt  <= lowLen - LEN_W'(1);
    end else if (ctl.loadHigh) begin
      preCnt <= '0;
      phCnt  <= highLen - LEN_W'(1);
    end else if (ctl.count) begin
      if (preWrap) begin
        preCnt <= '0;
        if (phCnt != '0) phCnt <= phCnt - LEN_W'(1);
      end else begin
        preCnt <= preCnt + PSC_W'(1);
      end
    end
  end

endmodule

// File: rtl/sclPhaseCtrl.sv
module sclPhaseCtrl
  import sclGenPkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   runEn,
  input  logic   genEn,
  input  logic   sclIn,
  input  logic   atLast,
  output dpCtl_t ctl,
  output logic   sclDriveLow,
  output logic   phaseStrobe
);

  phaseState_t state;
  phaseState_t nextState;
  logic        phaseEnd;

  always_comb begin
    ctl       = '0;
    nextState = state;
    phaseEnd  = 1'b0;
    if (!runEn) begin
      ctl.clear = 1'b1;
      nextState = ST_IDLE;
    end else begin
      case (state)
        ST_IDLE: begin
          if (genEn) begin
            ctl.loadLow = 1'b1;
            nextState   = ST_LOW;
          end
        end
        ST_LOW: begin
          ctl.count = genEn;
          phaseEnd  = genEn && atLast;
          if (phaseEnd) begin
            ctl.loadHigh = 1'b1;
            nextState    = ST_HIGH;
          end
        end
        ST_HIGH: begin
          // a low line during the high phase means another device stretches
          ctl.count = genEn && sclIn;
          phaseEnd  = genEn && sclIn && atLast;
          if (phaseEnd) begin
            ctl.loadLow = 1'b1;
            nextState   = ST_LOW;
          end
        end
        default: nextState = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      sclDriveLow <= 1'b0;
      phaseStrobe <= 1'b0;
    end else begin
      state       <= nextState;
      sclDriveLow <= (nextState == ST_LOW);
      phaseStrobe <= ctl.loadLow || ctl.loadHigh;
    end
  end

endmodule

// File: rtl/sclClockGen.sv
module sclClockGen
  import sclGenPkg::*;
#(
  parameter int PSC_W        = 8,
  parameter int CNT_W        = 16,
  parameter bit FIXED_OFFSET = 1'b0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             runEn,
  input  logic             genEn,
  input  logic             cfgWe,
  input  logic [1:0]       cfgSel,
  input  logic [CNT_W-1:0] cfgData,
  input  logic             sclIn,
  output logic             sclDriveLow,
  output logic             phaseStrobe
);

  dpCtl_t ctl;
  logic   atLast;

  sclPhaseCtrl uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .runEn       (runEn),
    .genEn       (genEn),
    .sclIn       (sclIn),
    .atLast      (atLast),
    .ctl         (ctl),
    .sclDriveLow (sclDriveLow),
    .phaseStrobe (phaseStrobe)
  );

  sclDivDatapath #(
    .PSC_W        (PSC_W),
    .CNT_W        (CNT_W),
    .FIXED_OFFSET (FIXED_OFFSET)
  ) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .runEn   (runEn),
    .cfgWe   (cfgWe),
    .cfgSel  (cfgSel),
    .cfgData (cfgData),
    .ctl     (ctl),
    .atLast  (atLast)
  );

endmodule

// File: rtl/sclClockGenChk.sv
module sclClockGenChk (
  input logic clk,
  input logic rstN,
  input logic runEn,
  input logic genEn,
  input logic sclDriveLow,
  input logic phaseStrobe
);

  p_idle_released_r1: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |=> (!sclDriveLow && !phaseStrobe));

  p_freeze_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (runEn && !genEn) |=> ($stable(sclDriveLow) && !phaseStrobe));

  p_rise_strobe_r11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sclDriveLow) |-> phaseStrobe);

  p_fall_strobe_r11: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(sclDriveLow) && $past(runEn)) |-> phaseStrobe);

  p_strobe_single_r11: assert property (@(posedge clk) disable iff (!rstN)
    phaseStrobe |=> !phaseStrobe);

  p_strobe_edge_r11: assert property (@(posedge clk) disable iff (!rstN)
    (phaseStrobe && $past(runEn)) |-> !$stable(sclDriveLow));

endmodule

bind sclClockGen sclClockGenChk uChk (
  .clk         (clk),
  .rstN        (rstN),
  .runEn       (runEn),
  .genEn       (genEn),
  .sclDriveLow (sclDriveLow),
  .phaseStrobe (phaseStrobe)
);

// File: tb/sim_sclClockGen.sv
`timescale 1ns/1ps
module sim_sclClockGen;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        runEn = 1'b0;
  logic        genEn = 1'b1;
  logic        cfgWe = 1'b0;
  logic [1:0]  cfgSel = 2'd0;
  logic [15:0] cfgData = 16'd0;
  logic        stretch = 1'b0;
  logic        sel = 1'b0;
  logic        drv0, stb0, drv1, stb1;
  logic        sclIn0, sclIn1, monDrv, monStb;

  int checkCnt = 0;
  int failCnt  = 0;

  always #2.5 clk = ~clk;

  assign sclIn0 = ~drv0 & ~stretch;
  assign sclIn1 = ~drv1 & ~stretch;
  assign monDrv = sel ? drv1 : drv0;
  assign monStb = sel ? stb1 : stb0;

  sclClockGen #(.PSC_W(8), .CNT_W(16), .FIXED_OFFSET(1'b0)) u0 (
    .clk(clk), .rstN(rstN), .runEn(runEn), .genEn(genEn), .cfgWe(cfgWe),
    .cfgSel(cfgSel), .cfgData(cfgData), .sclIn(sclIn0),
    .sclDriveLow(drv0), .phaseStrobe(stb0));

  sclClockGen #(.PSC_W(8), .CNT_W(16), .FIXED_OFFSET(1'b1)) u1 (
    .clk(clk), .rstN(rstN), .runEn(runEn), .genEn(genEn), .cfgWe(cfgWe),
    .cfgSel(cfgSel), .cfgData(cfgData), .sclIn(sclIn1),
    .sclDriveLow(drv1), .phaseStrobe(stb1));

  typedef struct {
    logic  level;
    int    len;
    string tag;
  } expPhase_t;

  expPhase_t expQ[$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // scoreboard monitor: measures each phase between strobes
  int   runLen = 0;
  bit   armed = 1'b0;
  logic prevDrv = 1'b0;
  always @(negedge clk) begin
    if (!rstN || !runEn) begin
      armed  = 1'b0;
      runLen = 0;
    end else if (monStb) begin
      check(monDrv != prevDrv, "R11 strobe with level change", int'(monDrv), int'(!prevDrv));
      if (armed && expQ.size() > 0) begin
        expPhase_t e;
        e = expQ.pop_front();
        check((prevDrv == e.level) && (runLen == e.len), e.tag, runLen, e.len);
      end
      armed  = 1'b1;
      runLen = 1;
    end else begin
      runLen++;
    end
    prevDrv = monDrv;
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic writeCfg(input logic [1:0] s, input logic [15:0] d);
    cfgSel  = s;
    cfgData = d;
    cfgWe   = 1'b1;
    tick(1);
    cfgWe   = 1'b0;
  endtask

  function automatic int offsetOf(input int p, input bit fixedVar);
    if (fixedVar) return 6;
    if (p == 0) return 7;
    if (p == 1) return 6;
    return 5;
  endfunction

  task automatic pushPhases(input int lo, input int hi, input string tag);
    expQ.push_back('{1'b1, lo, {tag, " low"}});
    expQ.push_back('{1'b0, hi, {tag, " high"}});
    expQ.push_back('{1'b1, lo, {tag, " low2"}});
  endtask

  task automatic startRun(input string tag);
    runEn = 1'b1;
    tick(1);
    check(monDrv == 1'b1 && monStb == 1'b1, {"R2 start low ", tag}, int'(monDrv), 1);
  endtask

  task automatic finishRun(input int cycles, input string tag);
    tick(cycles);
    runEn = 1'b0;
    tick(2);
    check(expQ.size() == 0, {"all phases seen ", tag}, expQ.size(), 0);
    expQ.delete();
  endtask

  task automatic scenario(input int p, input int lo, input int hi, input bit fixedVar,
                          input string tag);
    int d, eLo, eHi;
    d   = offsetOf(p, fixedVar);
    eLo = (p + 1) * (lo + d);
    eHi = (p + 1) * (hi + d);
    writeCfg(2'd0, 16'(p));
    writeCfg(2'd1, 16'(lo));
    writeCfg(2'd2, 16'(hi));
    sel = fixedVar;
    pushPhases(eLo, eHi, tag);
    startRun(tag);
    finishRun(2 * eLo + eHi + 6, tag);
    sel = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failCnt++;
    checkCnt++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

  initial begin
    tick(3);
    check(drv0 == 1'b0 && stb0 == 1'b0, "R1 reset state u0", int'(drv0), 0);
    check(drv1 == 1'b0 && stb1 == 1'b0, "R1 reset state u1", int'(drv1), 0);
    rstN = 1'b1;
    tick(5);
    check(drv0 == 1'b0 && stb0 == 1'b0, "R1 idle while run low", int'(drv0), 0);

    // R3 R4 R5: three offsets, R7 zero high count
    scenario(0, 3, 2, 1'b0, "R3 R4 R5 p0");
    scenario(1, 4, 4, 1'b0, "R5 p1");
    scenario(3, 6, 0, 1'b0, "R7 R5 p3 zero high");
    // R6: constant offset variant
    scenario(0, 3, 2, 1'b1, "R6 fixed p0");
    scenario(3, 6, 0, 1'b1, "R6 fixed p3");

    // R8: writes while running are ignored
    writeCfg(2'd0, 16'd0);
    writeCfg(2'd1, 16'd3);
    writeCfg(2'd2, 16'd2);
    pushPhases(10, 9, "R8 write ignored");
    startRun("R8");
    writeCfg(2'd1, 16'd40);
    writeCfg(2'd0, 16'd5);
    writeCfg(2'd2, 16'd30);
    finishRun(40, "R8");
    pushPhases(10, 9, "R8 rerun unchanged");
    startRun("R8 rerun");
    finishRun(40, "R8 rerun");
    // R8: select 3 writes nothing
    writeCfg(2'd3, 16'd50);
    pushPhases(10, 9, "R8 select3 ignored");
    startRun("R8 sel3");
    finishRun(40, "R8 sel3");

    // R9: freeze during the low phase adds 5 cycles
    expQ.push_back('{1'b1, 15, "R9 frozen low"});
    expQ.push_back('{1'b0, 9, "R9 high after freeze"});
    startRun("R9");
    tick(2);
    genEn = 1'b0;
    for (int i = 0; i < 5; i++) begin
      tick(1);
      check(drv0 == 1'b1 && stb0 == 1'b0, "R9 frozen output", int'(drv0), 1);
    end
    genEn = 1'b1;
    finishRun(40, "R9");

    // R10: stretch of 6 cycles inside the high phase
    expQ.push_back('{1'b1, 10, "R10 low"});
    expQ.push_back('{1'b0, 15, "R10 stretched high"});
    expQ.push_back('{1'b1, 10, "R10 low after"});
    startRun("R10");
    for (int i = 0; i < 30 && drv0 == 1'b1; i++) tick(1);
    tick(2);
    stretch = 1'b1;
    tick(6);
    stretch = 1'b0;
    finishRun(30, "R10");

    // R12: stop mid-phase, then full restart
    runEn = 1'b1;
    tick(4);
    runEn = 1'b0;
    tick(1);
    check(drv0 == 1'b0 && stb0 == 1'b0, "R12 release on stop", int'(drv0), 0);
    tick(3);
    check(drv0 == 1'b0, "R12 stays released", int'(drv0), 0);
    pushPhases(10, 9, "R12 restart");
    startRun("R12");
    finishRun(40, "R12");

    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

endmodule